// File: doc/BRIEF.md
# Clocked Synchronous Serial Transceiver

This block is a full-duplex serial port. It moves 8-bit characters over one data-out line and one data-in line, both tied to a single shared synchronization clock. A character carries eight data bits and nothing else. There is no start bit, stop bit, parity bit or address bit. Bit 0 goes first.

The shift clock comes from one of two sources. In internal mode the block divides its system clock and drives the result out on a clock pin. That clock rests high and gives exactly eight low-going pulses per character. In external mode a clock from the pin input is passed through a synchronizer and its edges time the transfer.

The transmit path holds one byte in a buffer and one in a shift register. The receive path also has a shift register and a result buffer. Because both paths are buffered this way, a host can stream characters back to back. It talks to the block through single-cycle write and read strobes, using an empty flag, a full flag and an overrun flag.

Top module: `sync_serial_xcvr`

## Requirements
- R1: Each character is exactly 8 data bits sent least significant bit first. In internal mode each character produces exactly 8 falling edges on `sck_out`.
- R2: `txd` changes only in the system cycle in which the shift clock falls. It holds its value from one falling edge to the next, across the rising edge in between.
- R3: The receiver captures `rxd` at each rising shift-clock edge, least significant bit first. After the eighth capture the assembled byte appears on `rx_data`.
- R4: After the eighth bit of a character, `txd` keeps the value of bit 7 until the next character begins.
- R5: With `clk_sel[1]` = 0 (internal mode), `sck_oe` is 1. `sck_out` rests high when no character is in progress. Each low phase and each high phase during a transfer lasts `div_val`+1 system clocks.
- R6: With `clk_sel[1]` = 1 (external mode), `sck_oe` is 0 and `sck_out` stays high. Transfers are timed by `sck_in` after a two-flop synchronizer, and `rxd` is passed through a matching two-flop delay.
- R7: A `tx_wr` pulse while `tx_empty` = 1 fills the buffer and clears `tx_empty`. `tx_empty` sets again when the byte moves into the shift register on a falling edge. A `tx_wr` pulse while `tx_empty` = 0 is ignored.
- R8: If the transmit buffer is full when a character's eighth rising edge occurs, the next character's first falling edge follows one half period (`div_val`+1 clocks) later, with no idle gap.
- R9: `rx_full` sets when a received byte is placed in `rx_data`, and an `rx_rd` pulse clears `rx_full` and `rx_overrun`. If a character completes while `rx_full` = 1 and no read occurs in that cycle, `rx_overrun` sets and `rx_data` keeps the older byte.
- R10: After reset: `sck_out` = 1, `txd` = 1, `tx_empty` = 1, `rx_full` = 0, `rx_overrun` = 0.
- R11: Transmit and receive proceed at the same time on the same clock edges, each with its own independent data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_sel | input | 2 | Clock source; bit 1 = 1 selects external, bit 1 = 0 selects internal |
| div_val | input | 8 | Internal half period minus one, in system clocks |
| sck_in | input | 1 | External shift clock input |
| sck_out | output | 1 | Shift clock driven out in internal mode |
| sck_oe | output | 1 | Output enable for the clock pin |
| rxd | input | 1 | Serial data in |
| txd | output | 1 | Serial data out |
| tx_wr | input | 1 | Write strobe for the transmit buffer |
| tx_data | input | 8 | Byte to transmit |
| tx_empty | output | 1 | Transmit buffer can accept a byte |
| rx_rd | input | 1 | Read acknowledge for the receive buffer |
| rx_data | output | 8 | Last byte received |
| rx_full | output | 1 | Receive buffer holds an unread byte |
| rx_overrun | output | 1 | A byte was lost because the buffer was full |

## Verification
The hardest case to reach from the ports is a seamless hand-over from one character to the next. For that, the transmit buffer must be refilled inside the short window between the buffer draining into the shift register and the eighth rising edge. The stimulus polls `tx_empty` and writes the second byte as soon as the first has moved. It then writes a third byte at once, which must be dropped. With loopback on and no reads, the second received byte lands on a full buffer, so the gap timing, the ignored write and the overrun are all reached from one run.

// File: rtl/ssx_pkg.sv
package ssx_pkg;

  // Clock source decode: upper select bit chooses the pin clock.
  function automatic logic ssx_is_ext(input logic [1:0] sel);
    return sel[1];
  endfunction

  // LSB-first receive shift: new bit enters at the top.
  function automatic logic [7:0] ssx_shift_in(input logic [7:0] sh, input logic b);
    return {b, sh[7:1]};
  endfunction

  // Number of system clocks in one shift-clock phase.
  function automatic int unsigned ssx_half_clocks(input int unsigned div);
    return div + 1;
  endfunction

endpackage

// File: rtl/ssx_clkgen.sv
module ssx_clkgen #(
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_mode,
  input  logic [DIV_W-1:0] div_val,
  input  logic             want,
  input  logic             sck_in,
  input  logic             rxd,
  output logic             fall_ev,
  output logic             rise_ev,
  output logic             sck_level,
  output logic             rxd_smp
);

  logic [DIV_W-1:0]     cnt_q;
  logic                 sck_q;
  logic [SYNC_STAGES:0] sck_sh;
  logic [SYNC_STAGES-1:0] rxd_sh;
  logic                 int_fall, int_rise, ext_fall, ext_rise;

  // Internal divider: a phase ends when the count reaches zero.
  assign int_fall = sck_q && (cnt_q == '0) && want;
  assign int_rise = !sck_q && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || ext_mode) begin
      sck_q <= 1'b1;
      cnt_q <= '0;
    end else if (int_fall) begin
      sck_q <= 1'b0;
      cnt_q <= div_val;
    end else if (int_rise) begin
      sck_q <= 1'b1;
      cnt_q <= div_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // Pin clock and data synchronizers, plus one stage for edge detection.
  genvar g;
  generate
    for (g = 0; g <= SYNC_STAGES; g++) begin : g_sck
      always_ff @(posedge clk) begin
        if (!rst_n) sck_sh[g] <= 1'b1;
        else if (g == 0) sck_sh[g] <= sck_in;
        else sck_sh[g] <= sck_sh[(g == 0) ? 0 : g-1];
      end
    end
    for (g = 0; g < SYNC_STAGES; g++) begin : g_rxd
      always_ff @(posedge clk) begin
        if (!rst_n) rxd_sh[g] <= 1'b1;
        else if (g == 0) rxd_sh[g] <= rxd;
        else rxd_sh[g] <= rxd_sh[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign ext_fall = sck_sh[SYNC_STAGES] && !sck_sh[SYNC_STAGES-1];
  assign ext_rise = !sck_sh[SYNC_STAGES] && sck_sh[SYNC_STAGES-1];

  assign fall_ev   = ext_mode ? ext_fall : int_fall;
  assign rise_ev   = ext_mode ? ext_rise : int_rise;
  assign sck_level = sck_q;
  assign rxd_smp   = ext_mode ? rxd_sh[SYNC_STAGES-1] : rxd;

endmodule

// File: rtl/ssx_tx.sv
module ssx_tx #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall_ev,
  input  logic              rise_ev,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              buf_empty,
  output logic              active,
  output logic              load,
  output logic              want,
  output logic              txd
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(DATA_W - 1);

  logic [DATA_W-1:0] buf_q, sh_q;
  logic [IDX_W-1:0]  idx_q;
  logic              full_q, act_q, txd_q;
  logic              last_bit;

  assign last_bit = (idx_q == LAST);
  assign load     = fall_ev && full_q && (!act_q || last_bit);
  assign want     = full_q || (act_q && !last_bit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q  <= '0;
      full_q <= 1'b0;
    end else if (load) begin
      full_q <= 1'b0;
    end else if (wr && !full_q) begin
      buf_q  <= wdata;
      full_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q  <= '0;
      idx_q <= '0;
      act_q <= 1'b0;
      txd_q <= 1'b1;
    end else if (load) begin
      sh_q  <= buf_q;
      idx_q <= '0;
      act_q <= 1'b1;
      txd_q <= buf_q[0];
    end else if (fall_ev && act_q && !last_bit) begin
      idx_q <= idx_q + 1'b1;
      txd_q <= sh_q[idx_q + 1'b1];
    end else if (rise_ev && act_q && last_bit) begin
      act_q <= 1'b0;
    end
  end

  assign buf_empty = !full_q;
  assign active    = act_q;
  assign txd       = txd_q;

endmodule

// File: rtl/ssx_rx.sv
module ssx_rx #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise_ev,
  input  logic              rxd_smp,
  input  logic              rd,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              full,
  output logic              overrun
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(DATA_W - 1);

  logic [DATA_W-1:0] sh_q, buf_q;
  logic [IDX_W-1:0]  cnt_q;
  logic              full_q, ovr_q;
  logic [DATA_W-1:0] next_sh;

  assign next_sh = {rxd_smp, sh_q[DATA_W-1:1]};
  assign done    = rise_ev && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (rise_ev) begin
      sh_q  <= next_sh;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q  <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else if (done) begin
      if (full_q && !rd) begin
        ovr_q <= 1'b1;
      end else begin
        buf_q  <= next_sh;
        full_q <= 1'b1;
        if (rd) ovr_q <= 1'b0;
      end
    end else if (rd) begin
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end
  end

  assign rdata   = buf_q;
  assign full    = full_q;
  assign overrun = ovr_q;

endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        clk_sel,
  input  logic [DIV_W-1:0]  div_val,
  input  logic              sck_in,
  output logic              sck_out,
  output logic              sck_oe,
  input  logic              rxd,
  output logic              txd,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_empty,
  input  logic              rx_rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              rx_overrun
);

  import ssx_pkg::*;

  logic ext_mode;
  logic fall_ev, rise_ev, sck_level, rxd_smp;
  logic tx_want, tx_active, tx_load, rx_done;

  assign ext_mode = ssx_is_ext(clk_sel);

  ssx_clkgen #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_clk (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .div_val(div_val),
    .want(tx_want), .sck_in(sck_in), .rxd(rxd),
    .fall_ev(fall_ev), .rise_ev(rise_ev), .sck_level(sck_level), .rxd_smp(rxd_smp)
  );

  ssx_tx #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .fall_ev(fall_ev), .rise_ev(rise_ev),
    .wr(tx_wr), .wdata(tx_data), .buf_empty(tx_empty), .active(tx_active),
    .load(tx_load), .want(tx_want), .txd(txd)
  );

  ssx_rx #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .rise_ev(rise_ev), .rxd_smp(rxd_smp),
    .rd(rx_rd), .done(rx_done), .rdata(rx_data), .full(rx_full),
    .overrun(rx_overrun)
  );

  assign sck_out = sck_level;
  assign sck_oe  = !ext_mode;

endmodule

// File: rtl/ssx_checker.sv
module ssx_checker #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ext_mode,
  input logic              sck_out,
  input logic              txd,
  input logic              fall_ev,
  input logic              rise_ev,
  input logic              tx_wr,
  input logic              tx_empty,
  input logic              tx_load,
  input logic              tx_active,
  input logic              rx_rd,
  input logic              rx_full,
  input logic [DATA_W-1:0] rx_data
);

  a_r2_edges_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(fall_ev && rise_ev));

  a_r2_txd_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_ev |=> $stable(txd));

  a_r5_low_means_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_mode && !sck_out) |-> tx_active);

  a_r7_empty_from_load: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_empty) |-> $past(tx_load));

  a_r7_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && !tx_empty && !tx_load) |=> !tx_empty);

  a_r9_held_until_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !rx_rd) |=> (rx_full && $stable(rx_data)));

endmodule

bind sync_serial_xcvr ssx_checker #(.DATA_W(DATA_W)) i_ssx_checker (
  .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .sck_out(sck_out), .txd(txd),
  .fall_ev(fall_ev), .rise_ev(rise_ev), .tx_wr(tx_wr), .tx_empty(tx_empty),
  .tx_load(tx_load), .tx_active(tx_active), .rx_rd(rx_rd), .rx_full(rx_full),
  .rx_data(rx_data)
);

// File: tb/test_sync_serial_xcvr.sv
module test_sync_serial_xcvr;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] clk_sel = 2'b00;
  logic [7:0] div_val = 8'd0;
  logic       sck_in = 1'b1;
  logic       sck_out, sck_oe, txd;
  logic       rxd_ext = 1'b1;
  logic       loop_en = 1'b1;
  logic       tx_wr = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_empty, rx_rd = 1'b0, rx_full, rx_overrun;
  logic [7:0] rx_data;
  logic       rxd;

  always #2 clk = ~clk;
  assign rxd = loop_en ? txd : rxd_ext;

  sync_serial_xcvr i_sync_serial_xcvr (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .div_val(div_val),
    .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe), .rxd(rxd), .txd(txd),
    .tx_wr(tx_wr), .tx_data(tx_data), .tx_empty(tx_empty), .rx_rd(rx_rd),
    .rx_data(rx_data), .rx_full(rx_full), .rx_overrun(rx_overrun)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Line monitor for internal mode.
  int mon_en = 0, falls = 0, hi_len = 0, lo_len = 0, len_err = 0, txd_err = 0;
  int exp_half = 1, gap_len = -1;
  logic [15:0] cap = '0;
  logic prev_sck = 1'b1, prev_txd = 1'b1;

  always @(negedge clk) begin
    if (rst_n && mon_en != 0) begin
      if (prev_sck && !sck_out) begin
        if (falls > 0 && hi_len != exp_half) len_err++;
        if (falls == 8) gap_len = hi_len;
        cap = {txd, cap[15:1]};
        falls++;
        lo_len = 1;
      end else if (!prev_sck && sck_out) begin
        if (lo_len != exp_half) len_err++;
        hi_len = 1;
      end else if (sck_out) hi_len++;
      else lo_len++;
      if (txd != prev_txd && !(prev_sck && !sck_out)) txd_err++;
    end
    prev_sck = sck_out;
    prev_txd = txd;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic mon_clear(input int half);
    falls = 0; hi_len = 0; lo_len = 0; len_err = 0; txd_err = 0;
    gap_len = -1; cap = '0; exp_half = half;
  endtask

  task automatic write_tx(input logic [7:0] b);
    tx_data = b; tx_wr = 1'b1; tick(1); tx_wr = 1'b0;
  endtask

  task automatic read_rx();
    rx_rd = 1'b1; tick(1); rx_rd = 1'b0;
  endtask

  task automatic wait_idle(input int max);
    for (int i = 0; i < max; i++) begin
      if (sck_out && falls > 0 && falls % 8 == 0 && hi_len > 2 * exp_half + 2) break;
      tick(1);
    end
  endtask

  // Vector table: {divider, byte, expected half period}
  localparam logic [23:0] VEC [5] = '{
    {8'd0, 8'hA5, 8'd1}, {8'd1, 8'h3C, 8'd2}, {8'd3, 8'h01, 8'd4},
    {8'd2, 8'h80, 8'd3}, {8'd5, 8'hFF, 8'd6}
  };

  initial begin
    tick(4);
    rst_n = 1'b1;
    tick(1);
    // R10: reset state
    chk(sck_out === 1'b1, "R10 sck_out", sck_out, 1);
    chk(txd === 1'b1, "R10 txd", txd, 1);
    chk(tx_empty === 1'b1, "R10 tx_empty", tx_empty, 1);
    chk(rx_full === 1'b0 && rx_overrun === 1'b0, "R10 rx flags", {rx_full, rx_overrun}, 0);
    chk(sck_oe === 1'b1, "R5 sck_oe internal", sck_oe, 1);

    // Table walk: single characters in internal loopback
    mon_en = 1;
    for (int v = 0; v < 5; v++) begin
      div_val = VEC[v][23:16];
      mon_clear(int'(VEC[v][7:0]));
      write_tx(VEC[v][15:8]);
      wait_idle(400);
      chk(falls == 8, "R1 falls per char", falls, 8);
      chk(cap[15:8] == VEC[v][15:8], "R1 txd bits LSB first", cap[15:8], VEC[v][15:8]);
      chk(len_err == 0, "R5 phase length", len_err, 0);
      chk(txd_err == 0 && txd == VEC[v][15], "R2 R4 txd held", txd, VEC[v][15]);
      chk(rx_full && rx_data == VEC[v][15:8], "R3 rx byte", rx_data, VEC[v][15:8]);
      chk(tx_empty === 1'b1, "R7 empty after send", tx_empty, 1);
      read_rx();
      chk(rx_full === 1'b0, "R9 read clears", rx_full, 0);
    end

    // Back-to-back, dropped write, overrun
    div_val = 8'd4;
    mon_clear(5);
    write_tx(8'h5A);
    for (int i = 0; i < 20 && !tx_empty; i++) tick(1);
    write_tx(8'hC3);
    write_tx(8'h77);
    chk(tx_empty === 1'b0, "R7 second byte buffered", tx_empty, 0);
    wait_idle(600);
    tick(60);
    chk(falls == 16, "R7 third write dropped", falls, 16);
    chk(cap == 16'hC35A, "R8 two chars sent", cap, 16'hC35A);
    chk(gap_len == 5, "R8 no idle gap", gap_len, 5);
    chk(rx_overrun === 1'b1 && rx_data == 8'h5A, "R9 overrun keeps old", rx_data, 8'h5A);
    read_rx();
    chk(!rx_full && !rx_overrun, "R9 read clears overrun", {rx_full, rx_overrun}, 0);
    tick(80);
    chk(falls == 16 && sck_out, "R5 idle high", falls, 16);

    // External mode, full duplex with independent data
    mon_en = 0;
    clk_sel = 2'b10;
    loop_en = 1'b0;
    tick(4);
    chk(sck_oe === 1'b0 && sck_out === 1'b1, "R6 pin not driven", {sck_oe, sck_out}, 1);
    write_tx(8'h96);
    begin
      logic [7:0] got;
      logic [7:0] rpat;
      got = '0;
      rpat = 8'h4D;
      for (int b = 0; b < 8; b++) begin
        sck_in = 1'b0; rxd_ext = rpat[b];
        tick(8);
        got[b] = txd;
        sck_in = 1'b1;
        tick(8);
      end
      tick(8);
      chk(got == 8'h96, "R6 R11 external tx", got, 8'h96);
      chk(rx_full && rx_data == 8'h4D, "R11 external rx", rx_data, 8'h4D);
      chk(txd == 1'b1, "R4 msb held external", txd, 1);
    end
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule